// File: doc/BRIEF.md
# Banked Translation-Control Register Unit

This block keeps two copies of the short-descriptor translation control word, one for the secure world and one for the non-secure world. Each copy holds the raw 32-bit word as written, plus two masks derived from it whenever it is written. The region mask splits the virtual address space between the two translation base registers. The base mask aligns the table base taken from base register 0.

Writes go through a simple port that carries a bank index and a data word. A write lands on the next rising clock edge and changes only the bank it names. The `secure_state` input picks which bank drives the walk logic.

The walk logic is purely combinational. It takes a virtual address and the two base registers and returns three results: the first-level descriptor address, a flag that refuses the walk, and which base register was used. It also shows the raw word of the active bank so that other logic can decode it.

Top module: `tcr_bank_unit`

## Requirements
- R1: After reset both banks hold a control word of 0, a region mask of 0 and a base mask of 0xFFFFC000. In that state the walk uses base register 0, is not refused, and the table base is `ttb0 & 0xFFFFC000`.
- R2: When `wr_en` is high at a rising edge, `wr_data` is stored into bank `wr_bank` (0 = non-secure, 1 = secure), and its masks are recomputed at the same time. The other bank keeps all of its state.
- R3: Bits [2:0] of the written word give a split value N. The region mask becomes `~(0xFFFFFFFF >> N)`, so it covers the top N address bits.
- R4: The base mask becomes `~(0x3FFF >> N)`.
- R5: `secure_state` = 1 selects bank 1, and `secure_state` = 0 selects bank 0. `cur_ctl` shows the raw word of the selected bank.
- R6: `walk_sel_ttb1` is 1 exactly when the address has a set bit under the region mask. With N = 0 it is never 1.
- R7: When base register 1 is chosen, `walk_off` equals bit 5 of the selected control word. When base register 0 is chosen, `walk_off` equals bit 4.
- R8: The table base is `ttb1 & 0xFFFFC000` when base register 1 is chosen. Otherwise it is `ttb0 & base mask`.
- R9: `walk_addr` = table base | ((va >> 18) & 0x3FFC). Its two low bits are always 0.
- R10: The walk outputs follow `va`, `ttb0`, `ttb1` and `secure_state` in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_bank | input | 1 | Bank to write: 0 non-secure, 1 secure |
| wr_data | input | 32 | Control word to store |
| secure_state | input | 1 | Current security state; selects the active bank |
| va | input | 32 | Virtual address to translate |
| ttb0 | input | 32 | Translation base register 0 |
| ttb1 | input | 32 | Translation base register 1 |
| walk_addr | output | 32 | First-level descriptor address |
| walk_off | output | 1 | Walk refused by the disable bit of the chosen base |
| walk_sel_ttb1 | output | 1 | 1 when base register 1 was chosen |
| cur_ctl | output | 32 | Raw control word of the active bank |

## Verification
The bench sweeps every split value from 0 to 7 and all four disable-bit pairs in each bank. Each setting is checked against addresses placed just above and just below the split boundary, in both security states.

A design with an off-by-one shift would move the split boundary. The boundary addresses would then choose the wrong base register. A design that swaps PD0 and PD1 would refuse the wrong half of the address space.

A design that writes both banks, or reads the wrong bank, would show the wrong masks once `secure_state` is toggled. A design that applies the base mask to base register 1, or forgets to clear the two low index bits, would produce wrong descriptor addresses at large N.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    typedef enum logic {
        BANK_NS  = 1'b0,
        BANK_SEC = 1'b1
    } bank_e;

    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/tcr_mask_gen.sv
module tcr_mask_gen #(
    parameter int unsigned W       = 32,
    parameter int unsigned SPLIT_W = 3,
    parameter int unsigned ALIGN   = 14
) (
    input  logic [SPLIT_W-1:0] split_i,
    output logic [W-1:0]       region_o,
    output logic [W-1:0]       base_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] LOW_ONES = (W'(1) << ALIGN) - W'(1);

    always_comb begin
        region_o = ~(ALL_ONES >> split_i);
        base_o   = ~(LOW_ONES >> split_i);
    end
endmodule

// File: rtl/tcr_bank.sv
module tcr_bank #(
    parameter int unsigned W       = 32,
    parameter int unsigned SPLIT_W = 3,
    parameter int unsigned ALIGN   = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] data,
    output logic [W-1:0] ctl_q,
    output logic [W-1:0] region_q,
    output logic [W-1:0] base_q
);
    localparam logic [W-1:0] BASE_RST = ~((W'(1) << ALIGN) - W'(1));

    logic [W-1:0] region_d;
    logic [W-1:0] base_d;

    tcr_mask_gen #(.W(W), .SPLIT_W(SPLIT_W), .ALIGN(ALIGN)) u_mask (
        .split_i  (data[SPLIT_W-1:0]),
        .region_o (region_d),
        .base_o   (base_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            region_q <= '0;
            base_q   <= BASE_RST;
        end else if (we) begin
            ctl_q    <= data;
            region_q <= region_d;
            base_q   <= base_d;
        end
    end
endmodule

// File: rtl/tcr_walk_decode.sv
module tcr_walk_decode #(
    parameter int unsigned W         = 32,
    parameter int unsigned ALIGN     = 14,
    parameter int unsigned IDX_SHIFT = 18
) (
    input  logic [W-1:0] va,
    input  logic [W-1:0] region,
    input  logic [W-1:0] base_mask,
    input  logic         pd0,
    input  logic         pd1,
    input  logic [W-1:0] ttb0,
    input  logic [W-1:0] ttb1,
    output logic [W-1:0] addr,
    output logic         off,
    output logic         sel1
);
    localparam logic [W-1:0] LOW_ONES   = (W'(1) << ALIGN) - W'(1);
    localparam logic [W-1:0] ALIGN_MASK = ~LOW_ONES;
    localparam logic [W-1:0] IDX_MASK   = LOW_ONES & ~W'(3);

    logic [W-1:0] tbl_base;
    logic [W-1:0] idx;

    always_comb begin
        sel1 = |(va & region);
        idx  = (va >> IDX_SHIFT) & IDX_MASK;
        if (sel1) begin
            off      = pd1;
            tbl_base = ttb1 & ALIGN_MASK;
        end else begin
            off      = pd0;
            tbl_base = ttb0 & base_mask;
        end
        addr = tbl_base | idx;
    end
endmodule

// File: rtl/tcr_bank_unit.sv
module tcr_bank_unit #(
    parameter int unsigned W         = 32,
    parameter int unsigned SPLIT_W   = 3,
    parameter int unsigned ALIGN     = 14,
    parameter int unsigned IDX_SHIFT = 18,
    parameter int unsigned PD0_BIT   = 4,
    parameter int unsigned PD1_BIT   = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_bank,
    input  logic [W-1:0] wr_data,
    input  logic         secure_state,
    input  logic [W-1:0] va,
    input  logic [W-1:0] ttb0,
    input  logic [W-1:0] ttb1,
    output logic [W-1:0] walk_addr,
    output logic         walk_off,
    output logic         walk_sel_ttb1,
    output logic [W-1:0] cur_ctl
);
    import tcr_pkg::*;

    logic [W-1:0] ctl_a    [NUM_BANKS];
    logic [W-1:0] region_a [NUM_BANKS];
    logic [W-1:0] base_a   [NUM_BANKS];

    logic [W-1:0] cur_region;
    logic [W-1:0] cur_base;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        tcr_bank #(.W(W), .SPLIT_W(SPLIT_W), .ALIGN(ALIGN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_en && (wr_bank == 1'(g))),
            .data     (wr_data),
            .ctl_q    (ctl_a[g]),
            .region_q (region_a[g]),
            .base_q   (base_a[g])
        );
    end

    always_comb begin
        unique case (bank_e'(secure_state))
            BANK_SEC: begin
                cur_ctl    = ctl_a[1];
                cur_region = region_a[1];
                cur_base   = base_a[1];
            end
            default: begin
                cur_ctl    = ctl_a[0];
                cur_region = region_a[0];
                cur_base   = base_a[0];
            end
        endcase
    end

    tcr_walk_decode #(.W(W), .ALIGN(ALIGN), .IDX_SHIFT(IDX_SHIFT)) u_walk (
        .va        (va),
        .region    (cur_region),
        .base_mask (cur_base),
        .pd0       (cur_ctl[PD0_BIT]),
        .pd1       (cur_ctl[PD1_BIT]),
        .ttb0      (ttb0),
        .ttb1      (ttb1),
        .addr      (walk_addr),
        .off       (walk_off),
        .sel1      (walk_sel_ttb1)
    );
endmodule

// File: rtl/tcr_bank_unit_chk.sv
module tcr_bank_unit_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         wr_bank,
    input logic [W-1:0] wr_data,
    input logic         secure_state,
    input logic [W-1:0] va,
    input logic [W-1:0] ttb1,
    input logic [W-1:0] walk_addr,
    input logic         walk_off,
    input logic         walk_sel_ttb1,
    input logic [W-1:0] cur_ctl
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: the two low address bits are always clear
    a_r9_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        walk_addr[1:0] == 2'b00);

    // R8: a walk on base register 1 keeps its upper bits
    a_r8_ttb1_base: assert property (@(posedge clk) disable iff (!rst_n)
        walk_sel_ttb1 |-> walk_addr[W-1:14] == ttb1[W-1:14]);

    // R6: split value 0 never chooses base register 1
    a_r6_split0_no_ttb1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && $past(wr_data[2:0]) == 3'd0
         && $past(wr_bank) == secure_state) |-> !walk_sel_ttb1);

    // R3: split value 1 leaves only the top address bit in the region mask
    a_r3_split1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && $past(wr_data[2:0]) == 3'd1
         && $past(wr_bank) == secure_state) |-> walk_sel_ttb1 == va[W-1]);

    // R7: with both disable bits set, every walk is refused
    a_r7_both_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && $past(wr_data[5:4]) == 2'b11
         && $past(wr_bank) == secure_state) |-> walk_off);

    // R2: a write lands in the bank it names
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && $past(wr_bank) == secure_state)
        |-> cur_ctl == $past(wr_data));
endmodule

bind tcr_bank_unit tcr_bank_unit_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_bank       (wr_bank),
    .wr_data       (wr_data),
    .secure_state  (secure_state),
    .va            (va),
    .ttb1          (ttb1),
    .walk_addr     (walk_addr),
    .walk_off      (walk_off),
    .walk_sel_ttb1 (walk_sel_ttb1),
    .cur_ctl       (cur_ctl)
);

// File: tb/tcr_bank_unit_bench.sv
module tcr_bank_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [31:0] wr_data = '0;
    logic        secure_state = 1'b0;
    logic [31:0] va = '0;
    logic [31:0] ttb0 = '0;
    logic [31:0] ttb1 = '0;
    logic [31:0] walk_addr;
    logic        walk_off;
    logic        walk_sel_ttb1;
    logic [31:0] cur_ctl;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_ctl [2];

    always #10 clk = ~clk;

    tcr_bank_unit u_tcr_bank_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_data(wr_data), .secure_state(secure_state), .va(va),
        .ttb0(ttb0), .ttb1(ttb1), .walk_addr(walk_addr),
        .walk_off(walk_off), .walk_sel_ttb1(walk_sel_ttb1), .cur_ctl(cur_ctl)
    );

    task automatic do_write(input logic b, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_ctl[b] = d;
    endtask

    task automatic check_walk(input string req, input logic s, input logic [31:0] a,
                              input logic [31:0] t0, input logic [31:0] t1);
        logic [31:0] c, rm, bm, base, e_addr;
        logic        e_sel, e_off;
        int          n;
        secure_state = s; va = a; ttb0 = t0; ttb1 = t1;
        #1;
        c  = model_ctl[s];
        n  = int'(c[2:0]);
        rm = ~(32'hFFFF_FFFF >> n);
        bm = ~(32'h0000_3FFF >> n);
        e_sel = (a & rm) != 0;
        e_off = e_sel ? c[5] : c[4];
        base  = e_sel ? (t1 & 32'hFFFF_C000) : (t0 & bm);
        e_addr = base | ((a >> 18) & 32'h0000_3FFC);
        checks++;
        if (walk_sel_ttb1 !== e_sel || walk_off !== e_off || walk_addr !== e_addr
            || cur_ctl !== c) begin
            errors++;
            $display("FAIL %s: sel=%0b off=%0b addr=%h ctl=%h expected sel=%0b off=%0b addr=%h ctl=%h",
                     req, walk_sel_ttb1, walk_off, walk_addr, cur_ctl,
                     e_sel, e_off, e_addr, c);
        end
    endtask

    initial begin : watchdog
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] pats [8];
        model_ctl[0] = '0;
        model_ctl[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state in both banks
        check_walk("R1", 1'b0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8765_4321);
        check_walk("R1", 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // R2, R5: write secure bank only, non-secure bank untouched
        do_write(1'b1, 32'h0000_0037);
        check_walk("R2", 1'b0, 32'hF000_0000, 32'hAAAA_AAAA, 32'h5555_5555);
        check_walk("R5", 1'b1, 32'hF000_0000, 32'hAAAA_AAAA, 32'h5555_5555);
        check_walk("R5", 1'b1, 32'h0010_0000, 32'hAAAA_AAAA, 32'h5555_5555);

        // R3, R4, R6, R7, R8, R9: sweep split values and disable bits per bank
        for (int b = 0; b < 2; b++) begin
            for (int n = 0; n < 8; n++) begin
                for (int pd = 0; pd < 4; pd++) begin
                    do_write(1'(b), 32'hA5A5_0000 | 32'(pd << 4) | 32'(n) | 32'h0000_0C80);
                    pats[0] = 32'h0000_0000;
                    pats[1] = 32'hFFFF_FFFF;
                    pats[2] = 32'h8000_0000;
                    pats[3] = (n == 0) ? 32'h0000_0001 : (32'h1 << (32 - n));
                    pats[4] = (n == 0) ? 32'h7FFF_FFFF : ((32'h1 << (32 - n)) - 32'h1);
                    pats[5] = 32'h9E37_79B9 * 32'(n + 1);
                    pats[6] = 32'h01FC_0000 >> n;
                    pats[7] = 32'h0003_FFFF;
                    for (int p = 0; p < 8; p++) begin
                        check_walk("R3/R4/R6/R7/R8/R9", 1'(b), pats[p],
                                   32'hFFFF_FFFF - 32'(p), 32'h1357_9BDF + 32'(p));
                        check_walk("R5", 1'(1 - b), pats[p],
                                   32'h0F0F_0F0F, 32'hF0F0_F0F0);
                    end
                end
            end
        end

        // R10: same-cycle response to input changes without a clock edge
        do_write(1'b0, 32'h0000_0002);
        @(negedge clk);
        check_walk("R10", 1'b0, 32'h4000_0000, 32'h0000_0000, 32'hFFFF_FFFF);
        check_walk("R10", 1'b0, 32'h2000_0000, 32'hFFFF_FFFF, 32'h0000_0000);

        // R1: reset again restores both banks
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_ctl[0] = '0;
        model_ctl[1] = '0;
        check_walk("R1", 1'b0, 32'hC000_0000, 32'h89AB_CDEF, 32'h1111_1111);
        check_walk("R1", 1'b1, 32'hC000_0000, 32'h89AB_CDEF, 32'h1111_1111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule